// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block turns one bus request into the clock-by-clock strobe pattern of a small 8-bit processor bus, where the low address byte and the data byte share one multiplexed bus. Each clock period is one T-state. A request names a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then steps through the T-states of that kind. It drives the latch pulse, the read and write strobes, the memory/IO select, the high address byte and the multiplexed bus. It returns the byte it read and marks the final T-state with a done pulse.

The multiplexed bus appears as three ports: an output byte, an output enable and an input byte. An instruction engine drives the request port. It can chain cycles with no gap by presenting the next request during the final T-state of the current one. For example, a fetch followed by two idle cycles fills 10 T-states.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, and whenever no cycle is running, tstate is 0, rd_n and wr_n are 1, ale, io_m and done are 0, ad_oe is 0, addr_hi is 0 and req_ready is 1.
- R2: While a cycle runs, tstate shows 1 in the first T-state after acceptance and advances by one every clock until the cycle ends.
- R3: Kind encoding: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 bus idle. A fetch lasts 4 T-states and every other kind lasts 3. done and req_ready are high in the final T-state only.
- R4: In T1 of every kind except idle, ale is 1, addr_hi carries address bits 15:8, and ad_out carries bits 7:0 with ad_oe at 1. In T2 and T3, addr_hi keeps the high byte. ale is 0 in every other T-state.
- R5: For kinds 0, 1 and 3, rd_n is 0 in T2 and T3 only, and rdata takes ad_in at the clock edge that ends T3, holding it until the next read. T4 of a fetch drives no strobe, no bus and addr_hi 0.
- R6: For kinds 2 and 4, ad_out carries the write byte with ad_oe at 1 and wr_n at 0 in T2 and T3. wr_n stays 1 in every other T-state.
- R7: io_m is 1 for every T-state of kinds 3 and 4 and 0 for all other kinds.
- R8: A bus idle cycle (kind 5) keeps ale at 0, rd_n and wr_n at 1, ad_oe at 0 and addr_hi at 0 for all 3 T-states.
- R9: A request with req_valid at 1 is accepted at a clock edge only when the block is idle or in a final T-state. The accepted cycle's T1 follows that edge with no gap. A request seen in any other T-state, or one with kind 6 or 7, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind (encoding in R3) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | A request would be accepted at the next edge |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Multiplexed bus, outgoing byte |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_in | input | 8 | Multiplexed bus, incoming byte |
| ale | output | 1 | Address latch pulse, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for an I/O cycle, 0 for memory |
| rdata | output | 8 | Last byte read |
| done | output | 1 | Final T-state of a cycle |
| tstate | output | 3 | Current T-state, 0 when idle |

## Verification
On every clock, the assertions check the local timing rules. The latch pulse appears only in T1 and the strobes appear only in T2 and T3. The two strobes never overlap. The T-state index advances by one. done falls only in T-state 3 or 4, and the outputs are quiet whenever the block is idle. The bench scenarios cover what needs a known request. They check the byte values on addr_hi and ad_out, the captured read byte and the cycle length per kind. They also check back-to-back chaining such as fetch followed by two idle cycles, and that requests in mid-cycle or with kinds 6 and 7 are ignored.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_kind,
  input  logic [2*DW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic [DW-1:0]   addr_hi,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  input  logic [DW-1:0]   ad_in,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            io_m,
  output logic [DW-1:0]   rdata,
  output logic            done,
  output logic [2:0]      tstate
);
  localparam int AW = 2 * DW;
  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_MRD   = 3'd1;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [2:0] K_IDLE  = 3'd5;

  logic          busy;
  logic [2:0]    kind_q;
  logic [2:0]    t_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  wire is_rd  = (kind_q == K_FETCH) || (kind_q == K_MRD) || (kind_q == K_IORD);
  wire is_wr  = (kind_q == K_MWR) || (kind_q == K_IOWR);
  wire bus_on = busy && (kind_q != K_IDLE) && (t_q <= 3'd3);
  wire mid    = (t_q == 3'd2) || (t_q == 3'd3);
  wire [2:0] len = (kind_q == K_FETCH) ? 3'd4 : 3'd3;
  wire last   = busy && (t_q == len);
  wire accept = req_valid && req_ready && (req_kind <= K_IDLE);

  assign req_ready = !busy || last;
  assign done      = last;
  assign tstate    = busy ? t_q : 3'd0;
  assign ale       = bus_on && (t_q == 3'd1);
  assign addr_hi   = bus_on ? addr_q[AW-1:DW] : '0;
  assign ad_oe     = bus_on && ((t_q == 3'd1) || is_wr);
  assign ad_out    = !bus_on     ? '0 :
                     (t_q == 3'd1) ? addr_q[DW-1:0] :
                     is_wr       ? wdata_q : '0;
  assign rd_n      = !(bus_on && is_rd && mid);
  assign wr_n      = !(bus_on && is_wr && mid);
  assign io_m      = busy && ((kind_q == K_IORD) || (kind_q == K_IOWR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind_q  <= K_IDLE;
      t_q     <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (bus_on && is_rd && (t_q == 3'd3))
        rdata <= ad_in;
      if (accept) begin
        busy    <= 1'b1;
        kind_q  <= req_kind;
        t_q     <= 3'd1;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (last) begin
        busy <= 1'b0;
        t_q  <= 3'd0;
      end else if (busy) begin
        t_q <= t_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       io_m,
  input logic       ad_oe,
  input logic       done,
  input logic       req_ready,
  input logic [2:0] tstate
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == 3'd0) |-> (rd_n && wr_n && !ale && !io_m && !done && req_ready));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate != 3'd0 && !done) |=> (tstate == $past(tstate) + 3'd1));

  assert_done_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((tstate == 3'd3 || tstate == 3'd4) && req_ready));

  assert_ale_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (tstate == 3'd1 && ad_oe));

  assert_rd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (tstate == 3'd2 || tstate == 3'd3));

  assert_wr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ((tstate == 3'd2 || tstate == 3'd3) && ad_oe && rd_n));

  assert_io_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (tstate != 3'd0));

  assert_no_start_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate != 3'd0 && !done) |=> (tstate != 3'd1));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .io_m(io_m), .ad_oe(ad_oe), .done(done), .req_ready(req_ready),
  .tstate(tstate)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  ad_in = '0;
  logic        req_ready, ad_oe, ale, rd_n, wr_n, io_m, done;
  logic [7:0]  addr_hi, ad_out, rdata;
  logic [2:0]  tstate;

  int checks = 0;
  int errors = 0;
  bit pend = 1'b0;
  logic [7:0] pend_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .rdata(rdata),
    .done(done), .tstate(tstate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_rd(input logic [2:0] k);
    return k == 3'd0 || k == 3'd1 || k == 3'd3;
  endfunction
  function automatic bit is_wr(input logic [2:0] k);
    return k == 3'd2 || k == 3'd4;
  endfunction
  function automatic int len_of(input logic [2:0] k);
    return (k == 3'd0) ? 4 : 3;
  endfunction
  function automatic bit bus_t(input logic [2:0] k, input int t);
    return k != 3'd5 && t >= 1 && t <= 3;
  endfunction
  function automatic logic [7:0] exp_ad(input logic [2:0] k, input logic [15:0] a,
                                        input logic [7:0] d, input int t);
    if (!bus_t(k, t)) return 8'h00;
    if (t == 1) return a[7:0];
    return is_wr(k) ? d : 8'h00;
  endfunction

  task automatic check_quiet(input string req);
    chk(tstate == 3'd0, req, tstate, 0);
    chk(rd_n && wr_n && !ale && !io_m && !done && !ad_oe && req_ready && addr_hi == 8'h00,
        req, {rd_n, wr_n, ale, io_m, done, ad_oe, req_ready}, 7'b1100001);
  endtask

  task automatic check_pend();
    if (pend) begin
      chk(rdata == pend_val, "R5 rdata", rdata, pend_val);
      pend = 1'b0;
    end
  endtask

  task automatic run(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d,
                     input logic [7:0] rb, input bit inject);
    int n;
    n = len_of(k);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    for (int t = 1; t <= n; t++) begin
      @(negedge clk);
      if (t == 1) begin
        req_valid = 1'b0;
        ad_in = rb;
        check_pend();
      end
      chk(tstate == 3'(t), "R2 tstate", tstate, t);
      chk(ale == (k != 3'd5 && t == 1), "R4 ale", ale, (k != 3'd5 && t == 1));
      chk(addr_hi == (bus_t(k, t) ? a[15:8] : 8'h00), "R4 addr_hi", addr_hi,
          bus_t(k, t) ? a[15:8] : 8'h00);
      chk(ad_oe == (bus_t(k, t) && (t == 1 || is_wr(k))), "R6 ad_oe", ad_oe,
          bus_t(k, t) && (t == 1 || is_wr(k)));
      chk(ad_out == exp_ad(k, a, d, t), "R6 ad_out", ad_out, exp_ad(k, a, d, t));
      chk(rd_n == !(is_rd(k) && (t == 2 || t == 3)), "R5 rd_n", rd_n,
          !(is_rd(k) && (t == 2 || t == 3)));
      chk(wr_n == !(is_wr(k) && (t == 2 || t == 3)), "R6 wr_n", wr_n,
          !(is_wr(k) && (t == 2 || t == 3)));
      chk(io_m == (k == 3'd3 || k == 3'd4), "R7 io_m", io_m, (k == 3'd3 || k == 3'd4));
      if (k == 3'd5)
        chk(ale == 1'b0 && rd_n && wr_n && !ad_oe, "R8 idle quiet", {ale, rd_n, wr_n, ad_oe}, 4'b0110);
      chk(done == (t == n), "R3 done", done, (t == n));
      chk(req_ready == (t == n), "R9 ready", req_ready, (t == n));
      if (inject && t == 2) begin
        req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'hdead; req_wdata = 8'h55;
      end
      if (t == n - 1 && n == 4) req_valid = 1'b0;
      if (t == n) req_valid = 1'b0;
    end
    if (is_rd(k)) begin
      pend = 1'b1;
      pend_val = rb;
    end
  endtask

  task automatic gap();
    @(negedge clk);
    check_pend();
    check_quiet("R9 idle after cycle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b5e_ed01));
    repeat (2) @(negedge clk);
    check_quiet("R1 reset");
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after reset");

    run(3'd0, 16'h4250, 8'h00, 8'h34, 1'b0);
    run(3'd5, 16'h0000, 8'h00, 8'h00, 1'b0);
    run(3'd5, 16'h0000, 8'h00, 8'h00, 1'b0);
    gap();

    run(3'd1, 16'h546a, 8'h00, 8'hc3, 1'b1);
    gap();
    run(3'd4, 16'h00f0, 8'h12, 8'h00, 1'b1);
    gap();

    for (int i = 6; i <= 7; i++) begin
      req_valid = 1'b1; req_kind = 3'(i); req_addr = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      check_quiet("R9 bad kind ignored");
    end

    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = 3'($urandom % 6);
      run(k, 16'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
      if ($urandom % 2) gap();
    end
    gap();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule